// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

The block routes 32 single-bit data inputs to 32 single-bit data outputs. Each output selects one source input and has its own enable bit. One input may feed any number of outputs at the same time, so broadcast and multicast work with no extra logic. The data path is purely combinational from the active configuration to the outputs.

A slow host builds a new routing in a shadow configuration file while traffic keeps flowing through the current routing. It sets a destination (output) address register and a source (input) address register, each loaded by its own capture strobe. A falling edge on the active-low load strobe then writes `{enable, source}` into the shadow entry of the addressed output. A falling edge on the active-low configure strobe copies every shadow entry into the active latch in one clock, so the whole new routing takes effect at once. All controls are sampled on the system clock `clk_i`.

Top module: `xbar_cfg_switch`

## Requirements
- R1: After the asynchronous active-low reset, every shadow and active entry is zero, so all outputs are disabled and `data_o` is all zeros.
- R2: The destination address register takes `dst_addr_i` at the clock edge where `dst_clk_i` is first seen high after being low, and holds its value at all other edges.
- R3: The source address register takes `src_addr_i` at the clock edge where `src_clk_i` is first seen high after being low, and holds its value at all other edges.
- R4: At the clock edge where `load_ni` is first seen low after being high, the shadow entry of the captured destination is written. An entry is 6 bits: bit 5 is the enable, taken from `en_i` at that edge, and bits 4:0 are the captured source index. A load strobe held low writes only once.
- R5: Writes to the shadow file do not change `data_o` until a transfer happens.
- R6: At the clock edge where `cfg_ni` is first seen low after being high, all 32 shadow entries are copied into the active latch. From that edge onward, each enabled output `data_o[j]` equals `data_i[src]` for its active source.
- R7: One input can be routed to several outputs at once.
- R8: An output whose active enable bit is 0 drives 0 whatever its source input does.
- R9: When the load and configure strobes fall at the same edge, the write reaches the shadow file first and the transfer copies the updated entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all controls sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 32 | Switch data inputs |
| data_o | output | 32 | Switch data outputs |
| dst_addr_i | input | 5 | Destination output index to capture |
| dst_clk_i | input | 1 | Capture strobe for the destination address (rising) |
| src_addr_i | input | 5 | Source input index to capture |
| src_clk_i | input | 1 | Capture strobe for the source address (rising) |
| en_i | input | 1 | Enable value stored with a shadow write |
| load_ni | input | 1 | Active-low shadow write strobe (falling edge) |
| cfg_ni | input | 1 | Active-low shadow-to-active transfer strobe (falling edge) |

## Verification
The assertions assume that strobes and addresses are stable across a rising clock edge and that each strobe stays at a level for at least one full cycle, so every edge is seen exactly once. The bench changes all controls on the falling clock edge and holds each strobe level for a whole cycle. It does not change an address in the cycle that a write uses it, except in the test that checks an uncaptured address is ignored. The bench checks outputs only after data and configuration have settled, using its own copies of the shadow and active tables.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned NUM_IN  = 32;
  localparam int unsigned NUM_OUT = 32;
  localparam int unsigned SRC_W   = $clog2(NUM_IN);
  localparam int unsigned DST_W   = $clog2(NUM_OUT);
  localparam int unsigned ENT_W   = SRC_W + 1;  // {enable, source}
endpackage

// File: rtl/xbar_addr_reg.sv
module xbar_addr_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic stb_q;
  logic cap;

  assign cap = stb_i & ~stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      q_o   <= '0;
    end else begin
      stb_q <= stb_i;
      if (cap) q_o <= d_i;
    end
  end

  AST_ADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !stb_q) |=> q_o == $past(d_i)); // R2 R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stb_i && !stb_q) |=> $stable(q_o)); // R2 R3
endmodule

// File: rtl/xbar_cfg_file.sv
module xbar_cfg_file #(
  parameter int unsigned NUM_OUT = 32,
  parameter int unsigned SRC_W   = 5,
  parameter int unsigned DST_W   = 5,
  parameter int unsigned ENT_W   = SRC_W + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_ni,
  input  logic                            cfg_ni,
  input  logic [DST_W-1:0]                dst_i,
  input  logic [SRC_W-1:0]                src_i,
  input  logic                            en_i,
  output logic [NUM_OUT-1:0][ENT_W-1:0]   act_o
);
  logic                          load_q, cfg_q;
  logic                          load_fall, cfg_fall;
  logic [NUM_OUT-1:0]            dec;
  logic [NUM_OUT-1:0][ENT_W-1:0] shadow;
  logic [ENT_W-1:0]              new_ent;

  assign load_fall = load_q & ~load_ni;
  assign cfg_fall  = cfg_q & ~cfg_ni;
  assign new_ent   = {en_i, src_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b1;
      cfg_q  <= 1'b1;
    end else begin
      load_q <= load_ni;
      cfg_q  <= cfg_ni;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ent
    assign dec[i] = (dst_i == DST_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow[i] <= '0;
        act_o[i]  <= '0;
      end else begin
        if (load_fall && dec[i]) shadow[i] <= new_ent;
        // write-then-transfer when both strobes fall together
        if (cfg_fall) act_o[i] <= (load_fall && dec[i]) ? new_ent : shadow[i];
      end
    end
  end

  AST_DEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dec) == 1); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_fall |=> $stable(shadow)); // R4
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_fall |=> $stable(act_o)); // R5
  AST_XFER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fall |=> act_o == shadow); // R6 R9
endmodule

// File: rtl/xbar_mux.sv
module xbar_mux #(
  parameter int unsigned NUM_IN  = 32,
  parameter int unsigned NUM_OUT = 32,
  parameter int unsigned SRC_W   = 5,
  parameter int unsigned ENT_W   = SRC_W + 1
) (
  input  logic [NUM_IN-1:0]             data_i,
  input  logic [NUM_OUT-1:0][ENT_W-1:0] act_i,
  output logic [NUM_OUT-1:0]            data_o
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic [SRC_W-1:0] sel;
    logic             en;
    assign sel       = act_i[j][SRC_W-1:0];
    assign en        = act_i[j][ENT_W-1];
    assign data_o[j] = en & data_i[sel];
  end
endmodule

// File: rtl/xbar_cfg_switch.sv
module xbar_cfg_switch
  import xbar_pkg::*;
#(
  parameter int unsigned N_IN  = NUM_IN,
  parameter int unsigned N_OUT = NUM_OUT,
  localparam int unsigned SW   = $clog2(N_IN),
  localparam int unsigned DW   = $clog2(N_OUT),
  localparam int unsigned EW   = SW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  data_i,
  output logic [N_OUT-1:0] data_o,
  input  logic [DW-1:0]    dst_addr_i,
  input  logic             dst_clk_i,
  input  logic [SW-1:0]    src_addr_i,
  input  logic             src_clk_i,
  input  logic             en_i,
  input  logic             load_ni,
  input  logic             cfg_ni
);
  logic [DW-1:0]             dst_q;
  logic [SW-1:0]             src_q;
  logic [N_OUT-1:0][EW-1:0]  act;

  xbar_addr_reg #(.W(DW)) i_dst_reg (
    .clk_i, .rst_ni, .stb_i(dst_clk_i), .d_i(dst_addr_i), .q_o(dst_q)
  );

  xbar_addr_reg #(.W(SW)) i_src_reg (
    .clk_i, .rst_ni, .stb_i(src_clk_i), .d_i(src_addr_i), .q_o(src_q)
  );

  xbar_cfg_file #(.NUM_OUT(N_OUT), .SRC_W(SW), .DST_W(DW), .ENT_W(EW)) i_cfg (
    .clk_i, .rst_ni, .load_ni, .cfg_ni,
    .dst_i(dst_q), .src_i(src_q), .en_i, .act_o(act)
  );

  xbar_mux #(.NUM_IN(N_IN), .NUM_OUT(N_OUT), .SRC_W(SW), .ENT_W(EW)) i_mux (
    .data_i, .act_i(act), .data_o
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> data_o == '0); // R1
endmodule

// File: tb/test_xbar_cfg_switch.sv
module test_xbar_cfg_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] data_o;
  logic [4:0]  dst_addr = '0, src_addr = '0;
  logic        dst_clk = 1'b0, src_clk = 1'b0;
  logic        en = 1'b0, load_n = 1'b1, cfg_n = 1'b1;

  int checks = 0, errors = 0;
  logic [5:0] sh_m [32];
  logic [5:0] ac_m [32];

  // {dst, src, en}: broadcast of input 7 to 0..2, disabled entry, extremes
  localparam logic [10:0] VEC [10] = '{
    {5'd0, 5'd7, 1'b1}, {5'd1, 5'd7, 1'b1}, {5'd2, 5'd7, 1'b1},
    {5'd3, 5'd31, 1'b1}, {5'd31, 5'd0, 1'b1}, {5'd4, 5'd4, 1'b0},
    {5'd10, 5'd20, 1'b1}, {5'd20, 5'd10, 1'b1}, {5'd15, 5'd15, 1'b1},
    {5'd30, 5'd1, 1'b1}
  };

  localparam logic [31:0] PAT [4] = '{32'hA5C3_0F96, 32'h5A3C_F069, 32'h0000_0080, 32'hFFFF_FF7F};

  always #4 clk = ~clk;

  xbar_cfg_switch i_xbar_cfg_switch (
    .clk_i(clk), .rst_ni(rst_n), .data_i, .data_o,
    .dst_addr_i(dst_addr), .dst_clk_i(dst_clk),
    .src_addr_i(src_addr), .src_clk_i(src_clk),
    .en_i(en), .load_ni(load_n), .cfg_ni(cfg_n)
  );

  function automatic logic [31:0] model_out(logic [31:0] d);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = ac_m[j][5] & d[ac_m[j][4:0]];
    return r;
  endfunction

  task automatic check_all(string req);
    for (int p = 0; p < 4; p++) begin
      data_i = PAT[p];
      #1;
      checks++;
      if (data_o !== model_out(PAT[p])) begin
        errors++;
        $display("FAIL %s: data_o=%h expected=%h", req, data_o, model_out(PAT[p]));
      end
    end
  endtask

  task automatic set_dst(logic [4:0] a);
    @(negedge clk); dst_addr = a; dst_clk = 1'b1;
    @(negedge clk); dst_clk = 1'b0;
  endtask

  task automatic set_src(logic [4:0] a);
    @(negedge clk); src_addr = a; src_clk = 1'b1;
    @(negedge clk); src_clk = 1'b0;
  endtask

  task automatic do_load(logic e, logic [4:0] d, logic [4:0] s);
    @(negedge clk); en = e; load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
    sh_m[d] = {e, s};
  endtask

  task automatic do_xfer();
    @(negedge clk); cfg_n = 1'b0;
    @(negedge clk); cfg_n = 1'b1;
    for (int i = 0; i < 32; i++) ac_m[i] = sh_m[i];
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin sh_m[i] = '0; ac_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // table walk: write shadow, verify outputs unchanged, then transfer
    for (int v = 0; v < 10; v++) begin
      set_dst(VEC[v][10:6]);
      set_src(VEC[v][5:1]);
      do_load(VEC[v][0], VEC[v][10:6], VEC[v][5:1]);
      check_all("R5");
      do_xfer();
      check_all("R6");
    end
    // broadcast: walking-one on input 7 reaches outputs 0,1,2
    data_i = 32'h0000_0080; #1;
    checks++;
    if (data_o[2:0] !== 3'b111) begin
      errors++; $display("FAIL R7: data_o[2:0]=%b expected=111", data_o[2:0]);
    end
    // disabled output 4 stays 0 with its source high
    data_i = 32'hFFFF_FFFF; #1;
    checks++;
    if (data_o[4] !== 1'b0) begin
      errors++; $display("FAIL R8: data_o[4]=%b expected=0", data_o[4]);
    end

    // R2: changed address without capture strobe is ignored
    set_dst(5'd5); set_src(5'd9);
    @(negedge clk); dst_addr = 5'd6; src_addr = 5'd11;
    do_load(1'b1, 5'd5, 5'd9);
    do_xfer();
    check_all("R2");
    // R3: source capture alone retargets only the source
    set_src(5'd12);
    do_load(1'b1, 5'd5, 5'd12);
    do_xfer();
    check_all("R3");

    // R4: load held low writes once; later en change ignored
    set_dst(5'd8); set_src(5'd3);
    @(negedge clk); en = 1'b1; load_n = 1'b0;
    sh_m[8] = {1'b1, 5'd3};
    @(negedge clk); en = 1'b0;
    set_src(5'd2);
    @(negedge clk); load_n = 1'b1;
    do_xfer();
    check_all("R4");

    // R9: simultaneous load and configure
    set_dst(5'd9); set_src(5'd25);
    @(negedge clk); en = 1'b1; load_n = 1'b0; cfg_n = 1'b0;
    @(negedge clk); load_n = 1'b1; cfg_n = 1'b1;
    sh_m[9] = {1'b1, 5'd25};
    for (int i = 0; i < 32; i++) ac_m[i] = sh_m[i];
    check_all("R9");

    // R1: reset mid-operation clears everything
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 32; i++) begin sh_m[i] = '0; ac_m[i] = '0; end
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");
    do_xfer();
    check_all("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule